// File: doc/BRIEF.md
# Tone Presence Qualifier

This block converts a raw, per-clock "signal energy above threshold" flag into a debounced detect output. The output is active low. A receiver front end uses it in three ways: as the FSK carrier-present indication, as the call-progress-tone indication, and as the DTMF digit-valid strobe. The analog comparison that produces the raw flag and the tone filters sit upstream and are outside this block.

Time is counted in 1 ms ticks supplied on an input. The block therefore runs at any system clock rate. The assert time and the release time differ from each other, and both are taken from a table indexed by the operating mode and a 2-bit timing code:

- In FSK mode, the qualified output also clamps the demodulated data bit while no carrier is present.
- In DTMF receive mode, the edge where the output goes low captures the decoded 4-bit digit.

Mode input encoding: 0 = FSK, 1 = call-progress tone, 2 = DTMF receive, 3 = idle.

Top module: `presence_qualifier`

## Requirements
- R1: While `rst` is high at a clock edge, the edge sets `det_n` = 1, `rx_bit` = 1 and `digit` = 0.
- R2: `det_n` goes from 1 to 0 at the clock edge where `raw_hit` has been sampled high together with `tick` for the on-time number of ticks, with `raw_hit` high at every edge in between.
- R3: `det_n` goes from 0 to 1 at the edge where `raw_hit` has been sampled low together with `tick` for the off-time number of ticks, with `raw_hit` low at every edge in between.
- R4: In FSK mode (mode 0), the on/off times in ms are:

  | Timing code | On | Off |
  |---|---|---|
  | 0 | 450 | 35 |
  | 1 | 10 | 35 |
  | 2 | 10 | 20 |
  | 3 | 70 | 15 |

- R5: In DTMF mode (mode 2), the on/off times in ms are:

  | Timing code | On | Off |
  |---|---|---|
  | 1 | 25 | 25 |
  | 2 | 30 | 35 |
  | 3 | 40 | 25 |
  | 0 | 25 | 25 |

  Code 0 is reserved and acts like code 1.
- R6: In call-progress mode (mode 1), the on-time is 10 ms and the off-time is 25 ms, whatever the timing code.
- R7: A single edge where `raw_hit` agrees with the current detect state restarts the qualifying count from zero.
- R8: `rx_bit` is 1 after any edge at which `det_n` was 1 or the mode was not FSK. In FSK mode with `det_n` = 0, `rx_bit` follows `raw_bit` one cycle late.
- R9: `digit` loads `raw_digit` only at an edge where `det_n` falls while the mode is DTMF. At all other times `digit` holds its value.
- R10: At an edge where `mode` differs from its value at the previous edge, or where the mode is idle (3), `det_n` is set to 1 and the count is cleared.
- R11: An edge without `tick` does not advance the qualifying count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 1 ms |
| mode | input | 2 | 0 FSK, 1 call-progress, 2 DTMF, 3 idle |
| tcode | input | 2 | Timing code selecting on/off hold times |
| raw_hit | input | 1 | Raw energy-above-threshold flag |
| raw_bit | input | 1 | Raw demodulated FSK data bit |
| raw_digit | input | 4 | Raw decoded DTMF digit code |
| det_n | output | 1 | Qualified detect, active low |
| rx_bit | output | 1 | Gated receive data bit |
| digit | output | 4 | Digit captured on qualification |

## Verification
The bench holds a behavioural model of the block. Any wrong count, hold-time entry or state bit in the design moves the edge of `det_n` by at least one cycle. That error appears on the first cycle of the qualifying window where the design and the model disagree. A bad gating term shows on `rx_bit` within one cycle of a `det_n` change or mode change. A misplaced capture shows on `digit` at the edge where `det_n` falls, and stays visible until the next capture.

// File: rtl/qual_pkg.sv
package qual_pkg;
  typedef enum logic [1:0] {
    QM_FSK  = 2'd0,
    QM_CPT  = 2'd1,
    QM_DTMF = 2'd2,
    QM_IDLE = 2'd3
  } qmode_e;
endpackage

// File: rtl/qual_limit.sv
// Hold-time lookup: returns on and off times in ticks for mode and code.
module qual_limit
  import qual_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  qmode_e            mode,
  input  logic [1:0]        code,
  output logic [CNT_W-1:0]  on_lim,
  output logic [CNT_W-1:0]  off_lim
);
  int on_ms;
  int off_ms;

  always_comb begin
    on_ms  = 1;
    off_ms = 1;
    case (mode)
      QM_FSK: begin
        case (code)
          2'd0:    begin on_ms = 450; off_ms = 35; end
          2'd1:    begin on_ms = 10;  off_ms = 35; end
          2'd2:    begin on_ms = 10;  off_ms = 20; end
          default: begin on_ms = 70;  off_ms = 15; end
        endcase
      end
      QM_CPT: begin
        on_ms  = 10;
        off_ms = 25;
      end
      QM_DTMF: begin
        case (code)
          2'd2:    begin on_ms = 30; off_ms = 35; end
          2'd3:    begin on_ms = 40; off_ms = 25; end
          default: begin on_ms = 25; off_ms = 25; end  // code 0 reserved, same as 1
        endcase
      end
      default: begin
        on_ms  = 1;
        off_ms = 1;
      end
    endcase
    on_lim  = CNT_W'(on_ms);
    off_lim = CNT_W'(off_ms);
  end
endmodule

// File: rtl/qual_timer.sv
// Detect state and shared qualifying counter.
module qual_timer
  import qual_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hit,
  input  qmode_e            mode,
  input  logic [CNT_W-1:0]  on_lim,
  input  logic [CNT_W-1:0]  off_lim,
  output logic              hold_n,
  output logic              same_mode,
  output logic              set_now
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  qmode_e           mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_n_q;
  logic [CNT_W-1:0] lim;
  logic             present;
  logic             disagree;
  logic             clear;
  logic             expire;

  assign present   = ~hold_n_q;
  assign lim       = present ? off_lim : on_lim;
  assign disagree  = (hit != present);
  assign same_mode = (mode == mode_q);
  assign clear     = ~same_mode || (mode == QM_IDLE);
  assign expire    = disagree && tick && (cnt_q == lim - CNT_ONE);
  assign set_now   = expire && ~present && ~clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= mode;
      cnt_q    <= '0;
      hold_n_q <= 1'b1;
    end else begin
      mode_q <= mode;
      if (clear) begin
        cnt_q    <= '0;
        hold_n_q <= 1'b1;
      end else if (!disagree) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (expire) begin
          cnt_q    <= '0;
          hold_n_q <= ~hold_n_q;
        end else begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end

  assign hold_n = hold_n_q;
endmodule

// File: rtl/qual_out.sv
// Receive-data clamp and digit capture.
module qual_out
  import qual_pkg::*;
#(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  qmode_e           mode,
  input  logic             same_mode,
  input  logic             hold_n,
  input  logic             set_now,
  input  logic             raw_bit,
  input  logic [DIG_W-1:0] raw_digit,
  output logic             rx_bit,
  output logic [DIG_W-1:0] digit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit <= 1'b1;
      digit  <= '0;
    end else begin
      rx_bit <= (mode == QM_FSK && same_mode && !hold_n) ? raw_bit : 1'b1;
      if (set_now && mode == QM_DTMF)
        digit <= raw_digit;
    end
  end
endmodule

// File: rtl/presence_qualifier.sv
module presence_qualifier
  import qual_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       mode,
  input  logic [1:0]       tcode,
  input  logic             raw_hit,
  input  logic             raw_bit,
  input  logic [DIG_W-1:0] raw_digit,
  output logic             det_n,
  output logic             rx_bit,
  output logic [DIG_W-1:0] digit
);
  qmode_e           mode_e;
  logic [CNT_W-1:0] on_lim;
  logic [CNT_W-1:0] off_lim;
  logic             hold_n;
  logic             same_mode;
  logic             set_now;

  assign mode_e = qmode_e'(mode);

  qual_limit #(.CNT_W(CNT_W)) u_limit (
    .mode    (mode_e),
    .code    (tcode),
    .on_lim  (on_lim),
    .off_lim (off_lim)
  );

  qual_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .hit       (raw_hit),
    .mode      (mode_e),
    .on_lim    (on_lim),
    .off_lim   (off_lim),
    .hold_n    (hold_n),
    .same_mode (same_mode),
    .set_now   (set_now)
  );

  qual_out #(.DIG_W(DIG_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_e),
    .same_mode (same_mode),
    .hold_n    (hold_n),
    .set_now   (set_now),
    .raw_bit   (raw_bit),
    .raw_digit (raw_digit),
    .rx_bit    (rx_bit),
    .digit     (digit)
  );

  assign det_n = hold_n;
endmodule

// File: rtl/qual_chk.sv
module qual_chk #(
  parameter int DIG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       mode,
  input logic             raw_hit,
  input logic [DIG_W-1:0] raw_digit,
  input logic             det_n,
  input logic             rx_bit,
  input logic [DIG_W-1:0] digit
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (det_n && rx_bit && digit == '0));

  assert_fall_needs_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(det_n) |-> ($past(raw_hit) && $past(tick)));

  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(det_n) |-> (($past(!raw_hit) && $past(tick)) ||
                      ($past(mode) != $past(mode, 2)) || ($past(mode) == 2'd3)));

  assert_rx_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    (det_n || mode != 2'd0) |=> rx_bit);

  assert_digit_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$fell(det_n) |-> $stable(digit));

  assert_digit_load_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(det_n) && $past(mode) == 2'd2) |-> (digit == $past(raw_digit)));

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |=> det_n);
endmodule

bind presence_qualifier qual_chk #(.DIG_W(DIG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .mode      (mode),
  .raw_hit   (raw_hit),
  .raw_digit (raw_digit),
  .det_n     (det_n),
  .rx_bit    (rx_bit),
  .digit     (digit)
);

// File: tb/presence_qualifier_tb.sv
`timescale 1ns/1ps
module presence_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [1:0] tcode = 2'd0;
  logic       raw_hit = 1'b0;
  logic       raw_bit = 1'b0;
  logic [3:0] raw_digit = 4'd0;
  logic       det_n;
  logic       rx_bit;
  logic [3:0] digit;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  int tick_every = 1;
  int phase = 0;
  int bitcnt = 0;
  bit done = 0;

  // behavioural reference state
  bit   m_det = 0;
  int   m_cnt = 0;
  bit   m_rx = 1;
  int   m_digit = 0;
  int   m_mq = 0;
  int   fsk_on[4]   = '{450, 10, 10, 70};
  int   fsk_off[4]  = '{35, 35, 20, 15};
  int   dtmf_on[4]  = '{25, 25, 30, 40};
  int   dtmf_off[4] = '{25, 25, 35, 25};

  always #4 clk = ~clk;  // 125 MHz

  presence_qualifier u_dut (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .tcode(tcode),
    .raw_hit(raw_hit), .raw_bit(raw_bit), .raw_digit(raw_digit),
    .det_n(det_n), .rx_bit(rx_bit), .digit(digit)
  );

  function automatic int lim_of(int m, int c, bit off);
    if (m == 0) return off ? fsk_off[c] : fsk_on[c];
    if (m == 1) return off ? 25 : 10;
    if (m == 2) return off ? dtmf_off[c] : dtmf_on[c];
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_det = 0; m_cnt = 0; m_rx = 1; m_digit = 0; m_mq = int'(mode);
    end else begin
      m_rx = (mode == 2'd0 && int'(mode) == m_mq && m_det) ? raw_bit : 1'b1;
      if (int'(mode) != m_mq || mode == 2'd3) begin
        m_det = 0; m_cnt = 0;
      end else if (raw_hit == m_det) begin
        m_cnt = 0;
      end else if (tick) begin
        m_cnt = m_cnt + 1;
        if (m_cnt >= lim_of(int'(mode), int'(tcode), m_det)) begin
          m_det = !m_det;
          m_cnt = 0;
          if (m_det && mode == 2'd2) m_digit = int'(raw_digit);
        end
      end
      m_mq = int'(mode);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "det_n vs model", int'(det_n), int'(!m_det));
      chk(cur_req, "rx_bit vs model", int'(rx_bit), int'(m_rx));
      chk(cur_req, "digit vs model", int'(digit), m_digit);
    end
  end

  // tick and data pattern drivers
  always @(negedge clk) begin
    phase = (phase + 1 >= tick_every) ? 0 : phase + 1;
    tick <= (phase == 0);
    bitcnt++;
    raw_bit <= bitcnt[2] ^ bitcnt[0];
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qualify(int m, int c, int on_t, int off_t, string tag);
    cur_req = tag;
    mode = 2'(m); tcode = 2'(c); raw_hit = 1'b0; tick_every = 1;
    wait_n(3);
    raw_hit = 1'b1;
    wait_n(on_t - 1);
    chk(tag, "det_n one tick before on-time", int'(det_n), 1);
    wait_n(1);
    chk(tag, "det_n at on-time", int'(det_n), 0);
    raw_hit = 1'b0;
    wait_n(off_t - 1);
    chk(tag, "det_n one tick before off-time", int'(det_n), 0);
    wait_n(1);
    chk(tag, "det_n at off-time", int'(det_n), 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    wait_n(3);
    cur_req = "R1";
    chk("R1", "det_n in reset", int'(det_n), 1);
    chk("R1", "rx_bit in reset", int'(rx_bit), 1);
    chk("R1", "digit in reset", int'(digit), 0);
    rst = 1'b0;
    wait_n(2);

    // R2 R3 R4: FSK table
    qualify(0, 0, 450, 35, "R4");
    qualify(0, 1, 10, 35, "R4");
    qualify(0, 2, 10, 20, "R2");
    qualify(0, 3, 70, 15, "R3");

    // R5: DTMF table incl. reserved code
    qualify(2, 1, 25, 25, "R5");
    qualify(2, 2, 30, 35, "R5");
    qualify(2, 3, 40, 25, "R5");
    qualify(2, 0, 25, 25, "R5");

    // R6: call-progress ignores timing code
    qualify(1, 0, 10, 25, "R6");
    qualify(1, 3, 10, 25, "R6");

    // R7: interrupted presence and absence restart the count
    cur_req = "R7";
    mode = 2'd0; tcode = 2'd1; raw_hit = 1'b0;
    wait_n(3);
    raw_hit = 1'b1; wait_n(7);
    raw_hit = 1'b0; wait_n(1);
    raw_hit = 1'b1; wait_n(9);
    chk("R7", "det_n after restarted presence", int'(det_n), 1);
    wait_n(1);
    chk("R7", "det_n after full on-time", int'(det_n), 0);
    raw_hit = 1'b0; wait_n(30);
    raw_hit = 1'b1; wait_n(1);
    raw_hit = 1'b0; wait_n(34);
    chk("R7", "det_n after restarted absence", int'(det_n), 0);

    // R8: data passes while detected, clamped after release
    cur_req = "R8";
    wait_n(20);
    wait_n(1);
    chk("R8", "det_n released", int'(det_n), 1);
    for (int i = 0; i < 16; i++) begin
      wait_n(1);
      chk("R8", "rx_bit clamped without carrier", int'(rx_bit), 1);
    end
    raw_hit = 1'b1;
    wait_n(40);

    // R10: mode change while detected releases output
    cur_req = "R10";
    chk("R10", "det_n detected before switch", int'(det_n), 0);
    mode = 2'd1;
    wait_n(1);
    chk("R10", "det_n after mode change", int'(det_n), 1);
    chk("R8", "rx_bit in non-FSK mode", int'(rx_bit), 1);
    mode = 2'd3;
    wait_n(500);
    chk("R10", "det_n in idle mode", int'(det_n), 1);

    // R9: digit capture in DTMF
    cur_req = "R9";
    mode = 2'd2; tcode = 2'd2; raw_hit = 1'b0; raw_digit = 4'h9;
    wait_n(3);
    raw_hit = 1'b1;
    wait_n(30);
    chk("R9", "digit captured at valid edge", int'(digit), 9);
    raw_digit = 4'h5;
    wait_n(10);
    chk("R9", "digit held while valid", int'(digit), 9);
    raw_hit = 1'b0;
    wait_n(40);
    chk("R9", "digit held after release", int'(digit), 9);
    raw_hit = 1'b1;
    wait_n(30);
    chk("R9", "digit recaptured", int'(digit), 5);
    mode = 2'd0; tcode = 2'd1; raw_digit = 4'hC;
    wait_n(20);
    chk("R9", "digit unchanged by FSK detect", int'(digit), 5);

    // R11: sparse ticks
    cur_req = "R11";
    mode = 2'd1; raw_hit = 1'b0; tick_every = 4;
    wait_n(8);
    raw_hit = 1'b1;
    wait_n(20);
    chk("R11", "det_n with few ticks", int'(det_n), 1);
    wait_n(25);
    chk("R11", "det_n after ten ticks", int'(det_n), 0);
    tick_every = 1;
    wait_n(4);

    finish_run();
  end
endmodule